// File: doc/BRIEF.md
# Programming Mode Entry Gate

This block guards entry to non-volatile programming mode behind two scan data registers that a test access port reaches. The first is a one-bit core-hold register: a 1 keeps the processor core in reset, a 0 lets it run. The second is a 16-bit unlock register that must be loaded with one exact key. The block raises its program-mode output only while the key is armed and the core is held.

The TAP state machine and the instruction decoder sit outside the block. They hand it one select line per register and one-cycle capture, shift and update strobes, all on the test clock. A synchronous Test-Logic-Reset strobe clears both registers.

The block also enforces the order of the steps. On entry, the hold must already be set when the key is latched. On exit, clearing the hold drops program mode at once, and the mode does not come back until the key is loaded again. Each register can be read back: a capture copies its held value into its shift chain.

Top module: `prog_entry_gate`

## Requirements
- R1: A completed update on the hold register (capture, shift, update while the hold select is high) sets the core-hold output to the shifted-in bit: 1 holds the core in reset, 0 releases it.
- R2: Program mode rises in the cycle after an update on the unlock register latches exactly 16'hA370 while the core-hold output is 1.
- R3: An update that latches any other unlock value leaves program mode low.
- R4: Latching 16'h0000 into the unlock register drops program mode in the cycle after the update.
- R5: A key latched while the core-hold output is 0 never enables program mode, including after the hold is set later.
- R6: Program mode is never high while the core-hold output is 0. Clearing the hold drops program mode, and setting the hold again does not restore it without a new key update.
- R7: A capture loads the selected register's held value into its chain. The chain shifts towards bit 0, takes TDI in at the top bit and shows bit 0 on TDO, so the first bit out is the least significant bit.
- R8: A Test-Logic-Reset strobe clears the hold, the unlock register and program mode at the next clock edge. An asynchronous active-low reset does the same.
- R9: Capture and shift without an update change neither the held registers nor program mode.
- R10: With neither select high, TDO is 0 and the strobes have no effect. When both selects are high, the unlock register has priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tlr_i | input | 1 | Test-Logic-Reset strobe, synchronous clear |
| sel_hold_i | input | 1 | Core-hold register selected |
| sel_key_i | input | 1 | Unlock register selected |
| capture_i | input | 1 | Capture-DR strobe |
| shift_i | input | 1 | Shift-DR strobe |
| update_i | input | 1 | Update-DR strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out of the selected chain |
| core_hold_o | output | 1 | Holds the processor core in reset |
| prog_mode_o | output | 1 | Programming mode enabled |

## Verification
The bench builds the block with its default 16-bit key width and key value, so that the real unlock code is the one under test. Every key with a single bit flipped is tried, along with all 256 low-byte values under the key's high byte. This shows that only the exact pattern arms the mode and that each latched value reads back correctly. Short directed sequences then try both entry orders and the exit order, an aborted scan with no update, scans with no register selected, and Test-Logic-Reset.

// File: rtl/peg_pkg.sv
package peg_pkg;

    // Which scan chain drives the serial output
    typedef enum logic [1:0] {
        CH_NONE = 2'd0,
        CH_HOLD = 2'd1,
        CH_KEY  = 2'd2
    } chain_sel_e;

    // Unlock register has priority when both selects are high
    function automatic chain_sel_e pick_chain(input logic sel_hold, input logic sel_key);
        if (sel_key)       return CH_KEY;
        else if (sel_hold) return CH_HOLD;
        else               return CH_NONE;
    endfunction

    typedef struct packed {
        logic armed;
    } mode_state_t;

endpackage

// File: rtl/peg_dr_chain.sv
module peg_dr_chain #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             sel_i,
    input  logic             capture_i,
    input  logic             shift_i,
    input  logic             update_i,
    input  logic             si_i,
    output logic             so_o,
    output logic [WIDTH-1:0] chain_o,
    output logic [WIDTH-1:0] held_o
);

    typedef struct packed {
        logic [WIDTH-1:0] chain;
        logic [WIDTH-1:0] held;
    } dr_state_t;

    dr_state_t st_d, st_q;
    logic [WIDTH-1:0] shifted;

    // Chain moves towards bit 0; serial input enters at the top bit
    generate
        if (WIDTH == 1) begin : g_single
            assign shifted = si_i;
        end else begin : g_multi
            assign shifted = {si_i, st_q.chain[WIDTH-1:1]};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.chain = '0;
            st_d.held  = '0;
        end else if (sel_i) begin
            if (capture_i)     st_d.chain = st_q.held;
            else if (shift_i)  st_d.chain = shifted;
            if (update_i)      st_d.held  = st_q.chain;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign so_o    = st_q.chain[0];
    assign chain_o = st_q.chain;
    assign held_o  = st_q.held;

endmodule

// File: rtl/peg_mode_ctl.sv
module peg_mode_ctl
    import peg_pkg::*;
#(
    parameter int unsigned       KEY_W   = 16,
    parameter logic [KEY_W-1:0]  KEY_VAL = 16'hA370
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             hold_q_i,
    input  logic             hold_upd_i,
    input  logic             hold_new_i,
    input  logic             key_upd_i,
    input  logic [KEY_W-1:0] key_new_i,
    output logic             prog_mode_o
);

    mode_state_t st_d, st_q;
    logic        key_hit;

    assign key_hit = (key_new_i == KEY_VAL);

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.armed = 1'b0;
        end else if (hold_upd_i && !hold_new_i) begin
            // Releasing the core always disarms
            st_d.armed = 1'b0;
        end else if (key_upd_i) begin
            // Key only counts when the core is already held
            st_d.armed = key_hit && hold_q_i;
        end else if (!hold_q_i) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign prog_mode_o = st_q.armed && hold_q_i;

endmodule

// File: rtl/prog_entry_gate.sv
module prog_entry_gate
    import peg_pkg::*;
#(
    parameter int unsigned       KEY_W   = 16,
    parameter logic [KEY_W-1:0]  KEY_VAL = 16'hA370
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tlr_i,
    input  logic sel_hold_i,
    input  logic sel_key_i,
    input  logic capture_i,
    input  logic shift_i,
    input  logic update_i,
    input  logic tdi_i,
    output logic tdo_o,
    output logic core_hold_o,
    output logic prog_mode_o
);

    localparam int unsigned HOLD_W = 1;

    chain_sel_e        active;
    logic              hold_sel, key_sel;
    logic              hold_so, key_so;
    logic [HOLD_W-1:0] hold_chain, hold_held;
    logic [KEY_W-1:0]  key_chain, key_held;

    assign active   = pick_chain(sel_hold_i, sel_key_i);
    assign hold_sel = (active == CH_HOLD);
    assign key_sel  = (active == CH_KEY);

    peg_dr_chain #(.WIDTH(HOLD_W)) i_hold_dr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (tlr_i),
        .sel_i     (hold_sel),
        .capture_i (capture_i),
        .shift_i   (shift_i),
        .update_i  (update_i),
        .si_i      (tdi_i),
        .so_o      (hold_so),
        .chain_o   (hold_chain),
        .held_o    (hold_held)
    );

    peg_dr_chain #(.WIDTH(KEY_W)) i_key_dr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (tlr_i),
        .sel_i     (key_sel),
        .capture_i (capture_i),
        .shift_i   (shift_i),
        .update_i  (update_i),
        .si_i      (tdi_i),
        .so_o      (key_so),
        .chain_o   (key_chain),
        .held_o    (key_held)
    );

    peg_mode_ctl #(.KEY_W(KEY_W), .KEY_VAL(KEY_VAL)) i_mode_ctl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_i       (tlr_i),
        .hold_q_i    (hold_held[0]),
        .hold_upd_i  (hold_sel && update_i),
        .hold_new_i  (hold_chain[0]),
        .key_upd_i   (key_sel && update_i),
        .key_new_i   (key_chain),
        .prog_mode_o (prog_mode_o)
    );

    always_comb begin
        unique case (active)
            CH_HOLD: tdo_o = hold_so;
            CH_KEY:  tdo_o = key_so;
            default: tdo_o = 1'b0;
        endcase
    end

    assign core_hold_o = hold_held[0];

    // Held unlock value is only observed through its chain on capture
    logic unused_key_held;
    assign unused_key_held = ^key_held;

endmodule

// File: rtl/peg_chk.sv
module peg_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic tlr_i,
    input logic sel_hold_i,
    input logic sel_key_i,
    input logic update_i,
    input logic tdo_o,
    input logic core_hold_o,
    input logic prog_mode_o
);

    // R6
    mode_needs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prog_mode_o |-> core_hold_o);

    // R8
    tlr_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tlr_i |=> (!prog_mode_o && !core_hold_o));

    // R2
    mode_rise_from_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(prog_mode_o) |-> $past(sel_key_i && update_i));

    // R5
    hold_rise_no_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(core_hold_o) |-> !prog_mode_o);

    // R10
    idle_tdo_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sel_hold_i && !sel_key_i) |-> !tdo_o);

    // R9
    hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!update_i && !tlr_i) |=> $stable(core_hold_o));

endmodule

bind prog_entry_gate peg_chk i_peg_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tlr_i       (tlr_i),
    .sel_hold_i  (sel_hold_i),
    .sel_key_i   (sel_key_i),
    .update_i    (update_i),
    .tdo_o       (tdo_o),
    .core_hold_o (core_hold_o),
    .prog_mode_o (prog_mode_o)
);

// File: tb/test_prog_entry_gate.sv
`timescale 1ns/1ps
module test_prog_entry_gate;

    localparam logic [15:0] KEY = 16'hA370;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tlr = 1'b0, sel_hold = 1'b0, sel_key = 1'b0;
    logic capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
    logic tdo, core_hold, prog_mode;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prog_entry_gate i_prog_entry_gate (
        .clk_i(clk), .rst_ni(rst_n), .tlr_i(tlr),
        .sel_hold_i(sel_hold), .sel_key_i(sel_key),
        .capture_i(capture), .shift_i(shift), .update_i(update),
        .tdi_i(tdi), .tdo_o(tdo), .core_hold_o(core_hold),
        .prog_mode_o(prog_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Capture, shift w bits of val LSB first, optional update; rb collects old contents
    task automatic scan(input bit key, input int w, input logic [15:0] val,
                        input bit do_upd, output logic [15:0] rb);
        @(negedge clk);
        sel_key = key; sel_hold = !key; capture = 1'b1;
        @(negedge clk);
        capture = 1'b0; shift = 1'b1;
        rb = '0;
        for (int i = 0; i < w; i++) begin
            tdi = val[i];
            #1 rb[i] = tdo;
            @(negedge clk);
        end
        shift = 1'b0;
        update = do_upd;
        @(negedge clk);
        update = 1'b0; sel_key = 1'b0; sel_hold = 1'b0; tdi = 1'b0;
    endtask

    task automatic put_key(input logic [15:0] v, output logic [15:0] rb);
        scan(1'b1, 16, v, 1'b1, rb);
    endtask

    task automatic put_hold(input logic v);
        logic [15:0] rb;
        scan(1'b0, 1, {15'd0, v}, 1'b1, rb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rb, prev, v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset prog", prog_mode, 0);
        chk("R8 reset hold", core_hold, 0);
        chk("R10 reset tdo", tdo, 0);

        // R1 / R7: hold register set, read back old value
        scan(1'b0, 1, 16'd1, 1'b1, rb);
        chk("R7 hold readback", rb[0], 0);
        chk("R1 hold set", core_hold, 1);
        scan(1'b0, 1, 16'd1, 1'b1, rb);
        chk("R7 hold readback one", rb[0], 1);

        // R2
        put_key(KEY, rb);
        chk("R7 key readback zero", rb, 0);
        chk("R2 key arms", prog_mode, 1);

        // R4
        put_key(16'h0000, rb);
        chk("R7 key readback", rb, KEY);
        chk("R4 zero exits", prog_mode, 0);

        // R3 single bit flips
        prev = 16'h0000;
        for (int b = 0; b < 16; b++) begin
            v = KEY ^ (16'd1 << b);
            put_key(v, rb);
            chk("R7 key readback flip", rb, prev);
            chk("R3 flip no mode", prog_mode, 0);
            put_key(KEY, rb);
            chk("R2 key rearms", prog_mode, 1);
            prev = KEY;
        end

        // R3 sweep of the low byte
        for (int x = 0; x < 256; x++) begin
            v = {8'hA3, x[7:0]};
            put_key(v, rb);
            chk("R7 sweep readback", rb, prev);
            chk("R3 sweep mode", prog_mode, (v == KEY) ? 1 : 0);
            prev = v;
        end

        // R5 wrong order: key before hold
        put_key(16'h0000, rb);
        put_hold(1'b0);
        chk("R1 hold clear", core_hold, 0);
        put_key(KEY, rb);
        chk("R5 key without hold", prog_mode, 0);
        put_hold(1'b1);
        chk("R5 late hold no mode", prog_mode, 0);
        put_key(KEY, rb);
        chk("R5 correct order", prog_mode, 1);

        // R6 hold cleared first
        put_hold(1'b0);
        chk("R6 hold drop kills mode", prog_mode, 0);
        put_hold(1'b1);
        chk("R6 no restore", prog_mode, 0);
        put_key(KEY, rb);
        chk("R6 rearmed", prog_mode, 1);

        // R9 aborted scans
        scan(1'b1, 16, 16'h0000, 1'b0, rb);
        chk("R9 key scan no update mode", prog_mode, 1);
        scan(1'b0, 1, 16'd0, 1'b0, rb);
        chk("R9 hold scan no update", core_hold, 1);
        chk("R9 hold scan mode", prog_mode, 1);
        scan(1'b1, 16, 16'h0000, 1'b0, rb);
        chk("R9 key value kept", rb, KEY);

        // R10 no select
        @(negedge clk);
        capture = 1'b1; tdi = 1'b1;
        @(negedge clk);
        capture = 1'b0; shift = 1'b1;
        #1 chk("R10 tdo idle", tdo, 0);
        @(negedge clk);
        shift = 1'b0; update = 1'b1;
        @(negedge clk);
        update = 1'b0; tdi = 1'b0;
        chk("R10 mode unchanged", prog_mode, 1);
        chk("R10 hold unchanged", core_hold, 1);

        // R10 both selects: unlock register wins
        @(negedge clk);
        sel_hold = 1'b1; sel_key = 1'b1; capture = 1'b1;
        @(negedge clk);
        capture = 1'b0;
        #1 chk("R10 both selects key bit0", tdo, KEY[0]);
        @(negedge clk);
        sel_hold = 1'b0; sel_key = 1'b0;

        // R8 Test-Logic-Reset
        @(negedge clk);
        tlr = 1'b1;
        @(negedge clk);
        tlr = 1'b0;
        chk("R8 tlr mode", prog_mode, 0);
        chk("R8 tlr hold", core_hold, 0);
        put_key(16'h0000, rb);
        chk("R8 tlr key cleared", rb, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule